// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a small device. A 16-state controller advances on every rising edge of the test clock, steered by the mode-select input. It has two branches. The instruction branch loads a 3-bit instruction register. The data branch moves bits through whichever data register that instruction selects.

Three data registers can sit between the serial input and the serial output:

- a fixed 32-bit identification word;
- a single bypass cell;
- a boundary chain with one cell per device pin.

The boundary chain samples the parallel pin inputs during capture and shifts them out. It also holds a second rank of update latches that drive the parallel pin outputs. A mode output tells the surrounding pad multiplexers when the update latches, and not the core, should drive the pins. That mode is active only under the external-test instruction.

The serial output changes on the falling clock edge. It is qualified by an output-enable that is high only while a shift state is active. An active-low asynchronous reset input forces the controller home at any time.

Top module: `tap_port`

## Requirements
- R1: Driving trstN low, with no clock edge, returns the controller to Test-Logic-Reset. It also drives tdoEn and bscanMode low and clears every update latch, so pinOut becomes all zeros.
- R2: On entry to Test-Logic-Reset the active instruction becomes IDCODE (code 110). Entry happens through trstN, or through five consecutive rising tck edges with tms high, from any state.
- R3: The instruction register is 3 bits wide and is shifted least significant bit first from tdi. Capture-IR loads the pattern 001, so the first three bits out on tdo are 1, 0, 0.
- R4: The active instruction changes only when the controller leaves Update-IR or enters Test-Logic-Reset. While a new code is being shifted in, the previous instruction's effects remain in place.
- R5: IDCODE (110) selects a 32-bit word that is shifted out least significant bit first. Bit 0 is 1, bits 11:1 hold the MFR_ID parameter, bits 27:12 hold PART_ID and bits 31:28 hold REV_ID.
- R6: BYPASS (111) selects a 1-bit register. Capture-DR loads 0 into it, and each bit on tdi appears on tdo exactly one shift later.
- R7: The undefined codes 001, 010, 011 and 101 behave exactly like BYPASS.
- R8: EXTEST (000) and SAMPLE/PRELOAD (100) both select the BSR_LEN-cell boundary chain. Capture-DR loads pinIn into it, and pinIn[0] is the first bit out. Bits from tdi enter at cell BSR_LEN-1.
- R9: pinOut changes only when leaving Update-DR, and only under EXTEST or SAMPLE/PRELOAD. It then takes the chain contents, with cell j driving pinOut[j].
- R10: bscanMode is high exactly while EXTEST is the active instruction. It stays low under SAMPLE/PRELOAD and under every other code.
- R11: tdo changes only on falling tck edges. tdoEn is high only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial test data in |
| pinIn | input | BSR_LEN | Parallel pin values for boundary capture |
| tdo | output | 1 | Serial test data out, updated on falling tck |
| tdoEn | output | 1 | Output enable for tdo (high in shift states) |
| pinOut | output | BSR_LEN | Boundary update latches toward the pads |
| bscanMode | output | 1 | Pads take pinOut instead of core values |

## Verification
The bench builds the port with BSR_LEN = 10 and distinct, non-symmetric MFR_ID, PART_ID and REV_ID values. A short chain lets the bench sweep all eight instruction codes with the same 40-bit data scan. That scan length runs past the end of every capturable register, so for each code the bench predicts the full output stream arithmetically: the captured word followed by the delayed input. It also predicts the resulting pin outputs and mode. Both reset paths, the hold of the instruction during an IR scan, and the falling-edge timing of the serial output are checked at the ports.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tapState_e;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b110;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} drPath_e;

  typedef struct packed {
    logic    captureDr;
    logic    shiftDr;
    logic    updateDr;
    logic    shiftIr;
    drPath_e path;
    logic    extest;
  } dpStrobe_t;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic      tck,
  input  logic      trstN,
  input  logic      tms,
  input  logic      tdi,
  output dpStrobe_t stb,
  output logic      irSerial
);

  tapState_e state, nextState;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irReg;

  always_comb begin
    unique case (state)
      TS_RESET:  nextState = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nextState = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nextState = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nextState = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  nextState = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: nextState = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nextState = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nextState = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: nextState = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nextState = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nextState = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  nextState = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: nextState = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nextState = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nextState = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: nextState = tms ? TS_SEL_DR : TS_IDLE;
      default:   nextState = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TS_RESET;
    else        state <= nextState;
  end

  // instruction shifter and active instruction
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
      irReg   <= OP_IDCODE;
    end else begin
      if (state == TS_CAP_IR)      irShift <= IR_CAPTURE;
      else if (state == TS_SH_IR)  irShift <= {tdi, irShift[IR_W-1:1]};
      if (nextState == TS_RESET)   irReg <= OP_IDCODE;
      else if (state == TS_UPD_IR) irReg <= irShift;
    end
  end

  assign irSerial = irShift[0];

  always_comb begin
    stb.captureDr = (state == TS_CAP_DR);
    stb.shiftDr   = (state == TS_SH_DR);
    stb.updateDr  = (state == TS_UPD_DR);
    stb.shiftIr   = (state == TS_SH_IR);
    stb.extest    = (irReg == OP_EXTEST);
    unique case (irReg)
      OP_EXTEST, OP_SAMPLE: stb.path = PATH_BSR;
      OP_IDCODE:            stb.path = PATH_ID;
      default:              stb.path = PATH_BYP;
    endcase
  end

  // run of consecutive tms-high edges, for the reset property
  logic [2:0] onesRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            onesRun <= '0;
    else if (!tms)         onesRun <= '0;
    else if (onesRun != 7) onesRun <= onesRun + 3'd1;
  end

  a_r2_five_ones: assert property (@(posedge tck) disable iff (!trstN)
    (onesRun >= 3'd5) |-> (state == TS_RESET));

  a_r2_reset_idcode: assert property (@(posedge tck) disable iff (!trstN)
    (state == TS_RESET) |-> (irReg == OP_IDCODE));

  a_r4_ir_hold: assert property (@(posedge tck) disable iff (!trstN)
    (state != TS_UPD_IR) |=> ($stable(irReg) || state == TS_RESET));

endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import tap_pkg::*;
#(
  parameter int           BSR_LEN = 98,
  parameter logic [10:0]  MFR_ID  = 11'h033,
  parameter logic [15:0]  PART_ID = 16'h0452,
  parameter logic [3:0]   REV_ID  = 4'h1
)(
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  dpStrobe_t          stb,
  input  logic               irSerial,
  input  logic [BSR_LEN-1:0] pinIn,
  output logic [BSR_LEN-1:0] pinOut,
  output logic               tdo,
  output logic               tdoEn
);

  localparam logic [ID_W-1:0] ID_WORD = {REV_ID, PART_ID, MFR_ID, 1'b1};

  logic [ID_W-1:0]    idShift;
  logic               bypReg;
  logic [BSR_LEN-1:0] bsrShift;
  logic [BSR_LEN-1:0] chainIn;
  logic               selBsr, selId, selByp;
  logic               drSerial, serialOut;

  assign selBsr = (stb.path == PATH_BSR);
  assign selId  = (stb.path == PATH_ID);
  assign selByp = (stb.path == PATH_BYP);

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      idShift <= ID_WORD;
      bypReg  <= 1'b0;
    end else begin
      if (selId && stb.captureDr)     idShift <= ID_WORD;
      else if (selId && stb.shiftDr)  idShift <= {tdi, idShift[ID_W-1:1]};
      if (selByp && stb.captureDr)    bypReg <= 1'b0;
      else if (selByp && stb.shiftDr) bypReg <= tdi;
    end
  end

  // boundary chain: capture/shift rank and update rank per cell
  assign chainIn = {tdi, bsrShift[BSR_LEN-1:1]};

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    always_ff @(posedge tck or negedge trstN) begin
      if (!trstN) begin
        bsrShift[i] <= 1'b0;
        pinOut[i]   <= 1'b0;
      end else begin
        if (selBsr && stb.captureDr)    bsrShift[i] <= pinIn[i];
        else if (selBsr && stb.shiftDr) bsrShift[i] <= chainIn[i];
        if (selBsr && stb.updateDr)     pinOut[i]   <= bsrShift[i];
      end
    end
  end

  always_comb begin
    unique case (stb.path)
      PATH_BSR: drSerial = bsrShift[0];
      PATH_ID:  drSerial = idShift[0];
      default:  drSerial = bypReg;
    endcase
    serialOut = stb.shiftIr ? irSerial : drSerial;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialOut;
      tdoEn <= stb.shiftDr | stb.shiftIr;
    end
  end

  a_r11_tdoen_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (stb.shiftDr || stb.shiftIr));

  a_r9_pinout_hold: assert property (@(posedge tck) disable iff (!trstN)
    !(stb.updateDr && selBsr) |=> $stable(pinOut));

  a_r6_bypass_delay: assert property (@(posedge tck) disable iff (!trstN)
    (stb.shiftDr && selByp) |=> (bypReg == $past(tdi)));

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int           BSR_LEN = 98,
  parameter logic [10:0]  MFR_ID  = 11'h033,
  parameter logic [15:0]  PART_ID = 16'h0452,
  parameter logic [3:0]   REV_ID  = 4'h1
)(
  input  logic               tck,
  input  logic               trstN,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pinIn,
  output logic               tdo,
  output logic               tdoEn,
  output logic [BSR_LEN-1:0] pinOut,
  output logic               bscanMode
);

  dpStrobe_t stb;
  logic      irSerial;

  tap_ctrl u_ctrl (
    .tck      (tck),
    .trstN    (trstN),
    .tms      (tms),
    .tdi      (tdi),
    .stb      (stb),
    .irSerial (irSerial)
  );

  tap_datapath #(
    .BSR_LEN (BSR_LEN),
    .MFR_ID  (MFR_ID),
    .PART_ID (PART_ID),
    .REV_ID  (REV_ID)
  ) u_dp (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .stb      (stb),
    .irSerial (irSerial),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .tdo      (tdo),
    .tdoEn    (tdoEn)
  );

  assign bscanMode = stb.extest;

  a_r10_mode_reset: assert property (@(posedge tck) disable iff (!trstN)
    $rose(bscanMode) |-> $past(tdoEn) == 1'b0);

endmodule

// File: tb/sim_tap_port.sv
`timescale 1ns/1ps
module sim_tap_port;

  localparam int          L    = 10;
  localparam logic [10:0] MFR  = 11'h2A5;
  localparam logic [15:0] PART = 16'hC3E1;
  localparam logic [3:0]  REV  = 4'h9;
  localparam int          NSH  = 40;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [L-1:0] pinIn = '0;
  logic tdo, tdoEn, bscanMode;
  logic [L-1:0] pinOut;

  int nChecks = 0, nFail = 0, edgeBad = 0;
  logic [31:0] idExp;
  logic [L-1:0] expPin;

  tap_port #(.BSR_LEN(L), .MFR_ID(MFR), .PART_ID(PART), .REV_ID(REV)) u0 (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .pinIn(pinIn),
    .tdo(tdo), .tdoEn(tdoEn), .pinOut(pinOut), .bscanMode(bscanMode));

  always #5 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sample outputs shown in the current state, then drive and clock
  task automatic step(input logic m, input logic d, output logic o, output logic e);
    @(negedge tck); #2;
    o = tdo; e = tdoEn;
    tms = m; tdi = d;
    @(posedge tck); #1;
    if (tdo !== o) edgeBad++;
  endtask

  task automatic scanIr(input logic [2:0] code, output logic [2:0] capOut, output int enBad);
    logic o, e, oldMode;
    enBad = 0;
    oldMode = bscanMode;
    step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o, e);
      capOut[i] = o;
      if (e !== 1'b1) enBad++;
    end
    step(1, 0, o, e);
    // now in Update-IR: previous instruction still in force (R4)
    chk(bscanMode === oldMode, "R4", {63'd0, bscanMode}, {63'd0, oldMode});
    step(0, 0, o, e);
  endtask

  task automatic scanDr(input logic [63:0] din, output logic [63:0] dout, output int enBad);
    logic o, e;
    enBad = 0; dout = '0;
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < NSH; i++) begin
      step(i == NSH-1, din[i], o, e);
      dout[i] = o;
      if (e !== 1'b1) enBad++;
    end
    step(1, 0, o, e); step(0, 0, o, e);
  endtask

  function automatic logic [63:0] expStream(input int capLen, input logic [63:0] cap, input logic [63:0] din);
    logic [63:0] r = '0;
    for (int k = 0; k < NSH; k++) r[k] = (k < capLen) ? cap[k] : din[k-capLen];
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [2:0] cap3;
    logic [63:0] dout, din, expOut;
    int enBad;
    logic o, e;
    idExp = {REV, PART, MFR, 1'b1};
    expPin = '0;

    #22;
    // R1: state while reset held
    chk(tdoEn === 1'b0 && bscanMode === 1'b0 && pinOut === '0, "R1",
        {tdoEn, bscanMode, 52'd0, pinOut}, 64'd0);
    @(negedge tck); trstN = 1'b1;
    step(0, 0, o, e);
    chk(e === 1'b0, "R11", {63'd0, e}, 64'd0);
    // R2/R5: IDCODE active after reset
    din = 64'h0000_00F0_F00D_BEEF;
    scanDr(din, dout, enBad);
    chk(dout === expStream(32, {32'd0, idExp}, din), "R5", dout, expStream(32, {32'd0, idExp}, din));
    chk(enBad == 0, "R11", enBad, 0);

    // sweep of every instruction code
    for (int op = 0; op < 8; op++) begin
      int capLen;
      logic [63:0] capV;
      logic [2:0] code = 3'(op);
      pinIn = L'(op * 97 + 301);
      din = 64'hA5C3_1E97_6B2D_F048 ^ (64'(op) * 64'h0123_4567_89AB_CDEF);
      scanIr(code, cap3, enBad);
      chk(cap3 === 3'b001, "R3", {61'd0, cap3}, 64'd1);
      chk(enBad == 0, "R11", enBad, 0);
      chk(bscanMode === (code == 3'b000), "R10", {63'd0, bscanMode}, {63'd0, code == 3'b000});
      case (code)
        3'b000, 3'b100: begin capLen = L;  capV = 64'(pinIn); end
        3'b110:         begin capLen = 32; capV = {32'd0, idExp}; end
        default:        begin capLen = 1;  capV = '0; end
      endcase
      scanDr(din, dout, enBad);
      expOut = expStream(capLen, capV, din);
      if (code == 3'b000 || code == 3'b100) begin
        chk(dout === expOut, "R8", dout, expOut);
        for (int j = 0; j < L; j++) expPin[j] = din[NSH-L+j];
      end else if (code == 3'b110)
        chk(dout === expOut, "R5", dout, expOut);
      else if (code == 3'b111)
        chk(dout === expOut, "R6", dout, expOut);
      else
        chk(dout === expOut, "R7", dout, expOut);
      chk(pinOut === expPin, "R9", 64'(pinOut), 64'(expPin));
      chk(tdoEn === 1'b0, "R11", {63'd0, tdoEn}, 64'd0);
    end

    // R2: five tms-high edges from Shift-DR under EXTEST
    scanIr(3'b000, cap3, enBad);
    chk(bscanMode === 1'b1, "R10", {63'd0, bscanMode}, 64'd1);
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < 5; i++) step(1, 0, o, e);
    chk(bscanMode === 1'b0, "R2", {63'd0, bscanMode}, 64'd0);
    step(0, 0, o, e);
    din = 64'h0000_0055_1234_5678;
    scanDr(din, dout, enBad);
    chk(dout === expStream(32, {32'd0, idExp}, din), "R2", dout, expStream(32, {32'd0, idExp}, din));

    // R1: asynchronous reset with EXTEST active and pins driven
    scanIr(3'b000, cap3, enBad);
    din = 64'hFFFF_FFFF_FFFF_FFFF;
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    @(posedge tck); #2;
    trstN = 1'b0;
    #1;
    chk(bscanMode === 1'b0 && tdoEn === 1'b0 && pinOut === '0, "R1",
        {tdoEn, bscanMode, 52'd0, pinOut}, 64'd0);
    @(posedge tck); @(posedge tck); @(negedge tck);
    trstN = 1'b1;
    tms = 1'b0;
    step(0, 0, o, e);
    din = 64'h0000_0099_CAFE_0001;
    scanDr(din, dout, enBad);
    chk(dout === expStream(32, {32'd0, idExp}, din), "R2", dout, expStream(32, {32'd0, idExp}, din));

    // R11: tdo never moved at a rising edge
    chk(edgeBad == 0, "R11", edgeBad, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule